// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit carries out 32-bit integer loads and stores against a data memory in which every cell holds one byte and cells are grouped into aligned blocks of four. A request supplies a base register value, a 16-bit raw offset together with a separate bit that chooses how the offset is widened to 32 bits, the store data, the access size (byte, halfword, word), a signedness flag for loads, a flag that allows or suppresses the load's register write, and the target address space. The unit forms the effective address and checks it for range, alignment and address-space legality. It then moves one whole aligned block: a plain read for loads, a direct write for word stores, and a read followed by a merged write for byte and halfword stores. For loads it picks the addressed lanes and widens them with sign or zero extension.

Requests use a valid/ready handshake. The requester holds every request field stable from the time it raises the valid signal until the single cycle in which ready is high. In that same cycle the response (error flag, register-write enable, load value) is presented. The memory port has a fixed read latency of one cycle.

Top module: `byte_lane_lsu`

## Requirements
- R1: The effective address is the base value plus the 16-bit offset with its upper 16 bits all set to the sign-select bit. Bit 15 of the offset does not decide the extension.
- R2: An effective address outside [0, 2^PTR_BITS) is reported as an error. A negative 32-bit value counts as outside. An erroneous request issues no memory read, no memory write and no register write.
- R3: A halfword address must be even and a word address must be a multiple of 4. A size code of 3 is illegal. Any violation is reported as an error with no memory access. Size codes are 0 for byte, 1 for halfword and 2 for word.
- R4: A load is legal only in address space 2. A store is legal only in spaces 2, 3 or 4. Any other space is an error. A legal write carries the request's space on the memory port.
- R5: The lane index is the two low address bits. Byte lane k occupies data bits 8k+7..8k. A halfword takes lanes 0-1 or lanes 2-3. A byte or halfword load with the unsigned flag at 0 is sign-extended to 32 bits, and with the flag at 1 it is zero-extended.
- R6: A word load returns the whole fetched block unchanged.
- R7: A byte or halfword store reads the enclosing block. In the following cycle it writes the block back with only the addressed lanes replaced, taken from the low byte or low halfword of the store data. All other lanes are unchanged.
- R8: A word store writes the block in the cycle the request is first seen, with no memory read.
- R9: The register-write output is high in the response cycle only for an error-free load whose write flag is 1. For stores it is always low.
- R10: Every memory address issued has its two low bits at zero. It equals the effective address with those bits cleared.
- R11: After reset, ready, response and both memory strobes are low. The response lasts exactly one cycle. It comes one cycle after the request is first seen for errors and word stores, and two cycles after for loads and byte/halfword stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqReady | output | 1 | Request completes this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| reqUnsigned | input | 1 | Zero-extend a byte/halfword load |
| reqRegWr | input | 1 | Allow the load's register write |
| reqSignSel | input | 1 | Fill value for the offset's upper 16 bits |
| reqSpace | input | 3 | Target address space |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 16 | Raw offset |
| reqStoreData | input | 32 | Store data |
| memRd | output | 1 | Block read strobe |
| memWe | output | 1 | Block write strobe |
| memSpace | output | 3 | Address space of the access |
| memAddr | output | PTR_BITS | Block-aligned cell address |
| memWdata | output | 32 | Block write data |
| memRdata | input | 32 | Block read data, one cycle after memRd |
| respValid | output | 1 | Response present (same cycle as reqReady) |
| respErr | output | 1 | Request was illegal |
| respRegWr | output | 1 | Write the destination register |
| respData | output | 32 | Extended load value |

## Verification
The bench targets the offset widening first. It uses offsets whose bit 15 disagrees with the sign-select bit, so a design that widened from bit 15 would land outside the range or on the wrong block. It probes the exact range edges, a negative address, misaligned halfword and word addresses, the illegal size code and illegal spaces for loads and stores. A design that let any of these through would show a memory write or read, or a missing error. Byte and halfword loads are taken from high and low lanes with the top bit set, so a lane mix-up or the wrong extension shows in the value. Partial stores are read back afterwards to catch damaged neighbouring lanes. The read count and latency expose a word store that needlessly reads, or a partial store that skips the read.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  localparam logic [2:0] SP_DATA     = 3'd2;
  localparam logic [2:0] SP_PUBLIC   = 3'd3;
  localparam logic [2:0] SP_DEFERRED = 3'd4;

  // strobes from control to datapath / memory
  typedef struct packed {
    logic memRd;
    logic memWe;
    logic latchLoad;
  } ctrl_strb_t;

  // status from datapath to control
  typedef struct packed {
    logic accessErr;
    logic needsRead;
  } dp_stat_t;

endpackage

// File: rtl/lsu_dpath.sv
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter int PTR_BITS  = 16,
  parameter int LIMB_BITS = 8,
  parameter int LANES     = 4,
  parameter int OFF_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrl_strb_t                 strb,
  input  logic                       reqStore,
  input  logic [1:0]                 reqSize,
  input  logic                       reqUnsigned,
  input  logic                       reqSignSel,
  input  logic [2:0]                 reqSpace,
  input  logic [LIMB_BITS*LANES-1:0] reqBase,
  input  logic [OFF_W-1:0]           reqOffset,
  input  logic [LIMB_BITS*LANES-1:0] reqStoreData,
  input  logic [LIMB_BITS*LANES-1:0] memRdata,
  output logic [PTR_BITS-1:0]        memAddr,
  output logic [LIMB_BITS*LANES-1:0] memWdata,
  output logic [LIMB_BITS*LANES-1:0] loadData,
  output dp_stat_t                   stat
);

  localparam int XLEN      = LIMB_BITS * LANES;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int HALF_W    = 2 * LIMB_BITS;

  size_e sizeCode;
  logic [XLEN-1:0] offExt;
  logic [XLEN-1:0] effAddr;
  logic [LANE_BITS-1:0] laneIdx;
  logic rangeOk, alignOk, spaceOk;
  logic [LIMB_BITS-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [XLEN-1:0] extVal;
  logic [XLEN-1:0] mergedBlk;
  logic [XLEN-1:0] loadReg;

  assign sizeCode = size_e'(reqSize);

  // address formation: offset widened by the separate select bit
  assign offExt  = {{(XLEN-OFF_W){reqSignSel}}, reqOffset};
  assign effAddr = reqBase + offExt;
  assign laneIdx = effAddr[LANE_BITS-1:0];

  // legality
  assign rangeOk = (effAddr[XLEN-1:PTR_BITS] == '0);

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: alignOk = 1'b1;
      SZ_HALF: alignOk = ~effAddr[0];
      SZ_WORD: alignOk = (laneIdx == '0);
      default: alignOk = 1'b0;
    endcase
  end

  always_comb begin
    if (reqStore)
      spaceOk = (reqSpace == SP_DATA) || (reqSpace == SP_PUBLIC) || (reqSpace == SP_DEFERRED);
    else
      spaceOk = (reqSpace == SP_DATA);
  end

  assign stat.accessErr = ~(rangeOk & alignOk & spaceOk);
  assign stat.needsRead = ~reqStore | (sizeCode != SZ_WORD);

  assign memAddr = {effAddr[PTR_BITS-1:LANE_BITS], {LANE_BITS{1'b0}}};

  // lane pick and extension for loads
  assign pickByte = memRdata[LIMB_BITS*laneIdx +: LIMB_BITS];
  assign pickHalf = memRdata[HALF_W*laneIdx[LANE_BITS-1:1] +: HALF_W];

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: extVal = reqUnsigned ? {{(XLEN-LIMB_BITS){1'b0}}, pickByte}
                                    : {{(XLEN-LIMB_BITS){pickByte[LIMB_BITS-1]}}, pickByte};
      SZ_HALF: extVal = reqUnsigned ? {{(XLEN-HALF_W){1'b0}}, pickHalf}
                                    : {{(XLEN-HALF_W){pickHalf[HALF_W-1]}}, pickHalf};
      default: extVal = memRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              loadReg <= '0;
    else if (strb.latchLoad) loadReg <= extVal;
  end
  assign loadData = loadReg;

  // read-modify-write merge, one slice per lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_BITS-1:0] LANE_ID = LANE_BITS'(i);
    logic laneHit;
    logic [LIMB_BITS-1:0] srcByte;
    always_comb begin
      unique case (sizeCode)
        SZ_BYTE: begin
          laneHit = (laneIdx == LANE_ID);
          srcByte = reqStoreData[LIMB_BITS-1:0];
        end
        SZ_HALF: begin
          laneHit = (laneIdx[LANE_BITS-1:1] == LANE_ID[LANE_BITS-1:1]);
          srcByte = reqStoreData[LIMB_BITS*(i%2) +: LIMB_BITS];
        end
        default: begin
          laneHit = 1'b1;
          srcByte = reqStoreData[LIMB_BITS*i +: LIMB_BITS];
        end
      endcase
    end
    assign mergedBlk[LIMB_BITS*i +: LIMB_BITS] =
      laneHit ? srcByte : memRdata[LIMB_BITS*i +: LIMB_BITS];
  end

  assign memWdata = stat.needsRead ? mergedBlk : reqStoreData;

  // a latched signed byte load must carry its sign into every upper bit
  assert_byte_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchLoad && !reqStore && sizeCode == SZ_BYTE && !reqUnsigned)
      |=> (loadData[XLEN-1:LIMB_BITS] == {(XLEN-LIMB_BITS){loadData[LIMB_BITS-1]}}));

  // a latched unsigned halfword load has a zero upper half
  assert_half_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchLoad && !reqStore && sizeCode == SZ_HALF && reqUnsigned)
      |=> (loadData[XLEN-1:HALF_W] == '0));

endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqStore,
  input  logic       reqRegWr,
  input  dp_stat_t   stat,
  output ctrl_strb_t strb,
  output logic       reqReady,
  output logic       respValid,
  output logic       respErr,
  output logic       respRegWr
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_DONE  = 2'd2
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (stat.accessErr) begin
            stateNxt = ST_DONE;
          end else if (!stat.needsRead) begin
            strb.memWe = 1'b1;
            stateNxt   = ST_DONE;
          end else begin
            strb.memRd = 1'b1;
            stateNxt   = ST_MERGE;
          end
        end
      end
      ST_MERGE: begin
        if (reqStore) strb.memWe     = 1'b1;
        else          strb.latchLoad = 1'b1;
        stateNxt = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign respValid = (state == ST_DONE);
  assign reqReady  = respValid;
  assign respErr   = respValid & stat.accessErr;
  assign respRegWr = respValid & ~reqStore & reqRegWr & ~stat.accessErr;

  assert_no_err_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.memWe |-> !stat.accessErr);

  assert_no_err_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.memRd |-> !stat.accessErr);

  assert_rmw_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.memWe && stat.needsRead) |-> $past(strb.memRd));

  assert_word_store_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.memWe && !stat.needsRead) |-> (!$past(strb.memRd) && !strb.memRd));

  assert_resp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.memRd, strb.memWe, strb.latchLoad}));

endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu
  import lsu_pkg::*;
#(
  parameter int PTR_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqStore,
  input  logic [1:0]          reqSize,
  input  logic                reqUnsigned,
  input  logic                reqRegWr,
  input  logic                reqSignSel,
  input  logic [2:0]          reqSpace,
  input  logic [31:0]         reqBase,
  input  logic [15:0]         reqOffset,
  input  logic [31:0]         reqStoreData,
  output logic                memRd,
  output logic                memWe,
  output logic [2:0]          memSpace,
  output logic [PTR_BITS-1:0] memAddr,
  output logic [31:0]         memWdata,
  input  logic [31:0]         memRdata,
  output logic                respValid,
  output logic                respErr,
  output logic                respRegWr,
  output logic [31:0]         respData
);

  ctrl_strb_t strb;
  dp_stat_t   stat;

  lsu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqStore  (reqStore),
    .reqRegWr  (reqRegWr),
    .stat      (stat),
    .strb      (strb),
    .reqReady  (reqReady),
    .respValid (respValid),
    .respErr   (respErr),
    .respRegWr (respRegWr)
  );

  lsu_dpath #(
    .PTR_BITS  (PTR_BITS),
    .LIMB_BITS (8),
    .LANES     (4),
    .OFF_W     (16)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .reqStore     (reqStore),
    .reqSize      (reqSize),
    .reqUnsigned  (reqUnsigned),
    .reqSignSel   (reqSignSel),
    .reqSpace     (reqSpace),
    .reqBase      (reqBase),
    .reqOffset    (reqOffset),
    .reqStoreData (reqStoreData),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .loadData     (respData),
    .stat         (stat)
  );

  assign memRd    = strb.memRd;
  assign memWe    = strb.memWe;
  assign memSpace = reqSpace;

endmodule

// File: tb/sim_byte_lane_lsu.sv
`timescale 1ns/100ps
module sim_byte_lane_lsu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqStore = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqUnsigned = 1'b0;
  logic        reqRegWr = 1'b0;
  logic        reqSignSel = 1'b0;
  logic [2:0]  reqSpace = 3'd2;
  logic [31:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [31:0] reqStoreData = '0;
  logic        memRd, memWe;
  logic [2:0]  memSpace;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        respValid, respErr, respRegWr;
  logic [31:0] respData;

  always #2.5 clk = ~clk;

  byte_lane_lsu #(.PTR_BITS(16)) u0 (.*);

  // memory model: 64 blocks, one-cycle read latency
  logic [31:0] mem [64];
  int rdCnt = 0, wrCnt = 0, alignBad = 0;
  logic [15:0] lastWrAddr;
  logic [31:0] lastWrData;
  logic [2:0]  lastWrSpace;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      mem[1]     <= 32'hF1E2_8374;
      mem[2]     <= 32'h1234_8765;
      memRdata   <= '0;
      lastWrAddr <= '0;
      lastWrData <= '0;
      lastWrSpace <= '0;
    end else begin
      if ((memRd || memWe) && memAddr[1:0] != 2'b00) alignBad <= alignBad + 1;
      if (memRd) begin
        memRdata <= mem[memAddr[7:2]];
        rdCnt    <= rdCnt + 1;
      end
      if (memWe) begin
        mem[memAddr[7:2]] <= memWdata;
        wrCnt       <= wrCnt + 1;
        lastWrAddr  <= memAddr;
        lastWrData  <= memWdata;
        lastWrSpace <= memSpace;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        uns;
    logic        f;
    logic        g;
    logic [2:0]  sp;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sd;
    logic        eErr;
    logic        eRw;
    logic [31:0] eData;
    logic        eWr;
    logic [15:0] eWrAddr;
    logic [31:0] eWrData;
    logic [1:0]  eRd;
    logic [2:0]  eLat;
    logic [4:0]  req;
  } vec_t;

  localparam int NV = 29;
  // st sz uns f g sp base off sd | eErr eRw eData eWr eWrAddr eWrData eRd eLat req
  localparam vec_t VEC [NV] = '{
    // R5: signed byte, lane 1 top bit set
    '{1'b0,2'd0,1'b0,1'b1,1'b0,3'd2,32'h4,16'h1,32'h0, 1'b0,1'b1,32'hFFFFFF83,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R5: unsigned byte lane 1
    '{1'b0,2'd0,1'b1,1'b1,1'b0,3'd2,32'h4,16'h1,32'h0, 1'b0,1'b1,32'h00000083,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R5: signed byte lane 0 positive
    '{1'b0,2'd0,1'b0,1'b1,1'b0,3'd2,32'h4,16'h0,32'h0, 1'b0,1'b1,32'h00000074,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R5: signed half upper lanes
    '{1'b0,2'd1,1'b0,1'b1,1'b0,3'd2,32'h4,16'h2,32'h0, 1'b0,1'b1,32'hFFFFF1E2,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R5: unsigned half upper lanes
    '{1'b0,2'd1,1'b1,1'b1,1'b0,3'd2,32'h4,16'h2,32'h0, 1'b0,1'b1,32'h0000F1E2,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R5: signed half lower lanes
    '{1'b0,2'd1,1'b0,1'b1,1'b0,3'd2,32'h8,16'h0,32'h0, 1'b0,1'b1,32'hFFFF8765,1'b0,16'h0,32'h0,2'd1,3'd3,5'd5},
    // R6: word load
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'h8,16'h0,32'h0, 1'b0,1'b1,32'h12348765,1'b0,16'h0,32'h0,2'd1,3'd3,5'd6},
    // R1: g=1 with offset top bit set -> 0xC-4 = 8
    '{1'b0,2'd2,1'b0,1'b1,1'b1,3'd2,32'hC,16'hFFFC,32'h0, 1'b0,1'b1,32'h12348765,1'b0,16'h0,32'h0,2'd1,3'd3,5'd1},
    // R1: g=0 same offset -> 0x10008 out of range
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'hC,16'hFFFC,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd1},
    // R1: g=1 with offset top bit clear -> 0x10004 + 0xFFFF0004 = 8
    '{1'b0,2'd2,1'b0,1'b1,1'b1,3'd2,32'h10004,16'h0004,32'h0, 1'b0,1'b1,32'h12348765,1'b0,16'h0,32'h0,2'd1,3'd3,5'd1},
    // R2: negative address
    '{1'b0,2'd0,1'b0,1'b1,1'b1,3'd2,32'h2,16'hFFF0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd2},
    // R2: last legal block
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'hFFFC,16'h0,32'h0, 1'b0,1'b1,32'h0,1'b0,16'h0,32'h0,2'd1,3'd3,5'd2},
    // R2: first address past the range
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'h10000,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd2},
    // R3: odd halfword load
    '{1'b0,2'd1,1'b0,1'b1,1'b0,3'd2,32'h5,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd3},
    // R3: word load at 6
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'h6,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd3},
    // R4: load from space 3
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd3,32'h8,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd4},
    // R4: load from space 4
    '{1'b0,2'd0,1'b0,1'b1,1'b0,3'd4,32'h8,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd4},
    // R9: legal load with write flag 0
    '{1'b0,2'd2,1'b0,1'b0,1'b0,3'd2,32'h8,16'h0,32'h0, 1'b0,1'b0,32'h0,1'b0,16'h0,32'h0,2'd1,3'd3,5'd9},
    // R7: byte store lane 1 of block 8
    '{1'b1,2'd0,1'b0,1'b1,1'b0,3'd2,32'h8,16'h1,32'hAABBCC5A, 1'b0,1'b0,32'h0,1'b1,16'h8,32'h12345A65,2'd1,3'd3,5'd7},
    // R7: read back, other lanes intact
    '{1'b0,2'd2,1'b0,1'b1,1'b0,3'd2,32'h8,16'h0,32'h0, 1'b0,1'b1,32'h12345A65,1'b0,16'h0,32'h0,2'd1,3'd3,5'd7},
    // R7: halfword store upper lanes, space 3
    '{1'b1,2'd1,1'b0,1'b1,1'b0,3'd3,32'hC,16'h2,32'h0000BEEF, 1'b0,1'b0,32'h0,1'b1,16'hC,32'hBEEF0000,2'd1,3'd3,5'd7},
    // R8: word store space 4
    '{1'b1,2'd2,1'b0,1'b1,1'b0,3'd4,32'h10,16'h0,32'hCAFEF00D, 1'b0,1'b0,32'h0,1'b1,16'h10,32'hCAFEF00D,2'd0,3'd2,5'd8},
    // R4: store to space 1
    '{1'b1,2'd0,1'b0,1'b1,1'b0,3'd1,32'h14,16'h0,32'h77, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd4},
    // R4: store to space 5
    '{1'b1,2'd2,1'b0,1'b1,1'b0,3'd5,32'h14,16'h0,32'h77, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd4},
    // R3: word store at 18
    '{1'b1,2'd2,1'b0,1'b1,1'b0,3'd2,32'h12,16'h0,32'h77, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd3},
    // R2: byte store past range
    '{1'b1,2'd0,1'b0,1'b1,1'b0,3'd2,32'h10000,16'h0,32'h77, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd2},
    // R3: halfword store at 7
    '{1'b1,2'd1,1'b0,1'b1,1'b0,3'd2,32'h7,16'h0,32'h77, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd3},
    // R9: store never raises the register write
    '{1'b1,2'd0,1'b0,1'b0,1'b0,3'd2,32'h14,16'h1,32'h11, 1'b0,1'b0,32'h0,1'b1,16'h14,32'h00001100,2'd1,3'd3,5'd9},
    // R3: size code 3
    '{1'b0,2'd3,1'b0,1'b1,1'b0,3'd2,32'h8,16'h0,32'h0, 1'b1,1'b0,32'h0,1'b0,16'h0,32'h0,2'd0,3'd2,5'd3}
  };

  initial begin
    // watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!reqReady,  11, "reset reqReady",  32'(reqReady),  32'h0);
    chk(!respValid, 11, "reset respValid", 32'(respValid), 32'h0);
    chk(!memWe,     11, "reset memWe",     32'(memWe),     32'h0);
    chk(!memRd,     11, "reset memRd",     32'(memRd),     32'h0);

    for (int v = 0; v < NV; v++) begin
      int rd0, wr0, lat;
      int rq;
      rq = int'(VEC[v].req);
      @(posedge clk);
      #1;
      reqStore     = VEC[v].st;
      reqSize      = VEC[v].sz;
      reqUnsigned  = VEC[v].uns;
      reqRegWr     = VEC[v].f;
      reqSignSel   = VEC[v].g;
      reqSpace     = VEC[v].sp;
      reqBase      = VEC[v].base;
      reqOffset    = VEC[v].off;
      reqStoreData = VEC[v].sd;
      reqValid     = 1'b1;
      rd0 = rdCnt;
      wr0 = wrCnt;
      lat = 0;
      do begin
        @(negedge clk);
        lat++;
      end while (!reqReady && lat < 20);

      chk(respValid == reqReady, 11, "respValid with ready", 32'(respValid), 32'(reqReady));
      chk(lat == int'(VEC[v].eLat), 11, "latency", 32'(lat), 32'(VEC[v].eLat));
      chk(respErr == VEC[v].eErr, rq, "error flag", 32'(respErr), 32'(VEC[v].eErr));
      chk(respRegWr == VEC[v].eRw, VEC[v].st ? 9 : rq, "reg write", 32'(respRegWr), 32'(VEC[v].eRw));
      if (VEC[v].eRw)
        chk(respData == VEC[v].eData, rq, "load data", respData, VEC[v].eData);
      chk((rdCnt - rd0) == int'(VEC[v].eRd), rq, "memory reads", 32'(rdCnt - rd0), 32'(VEC[v].eRd));
      chk((wrCnt - wr0) == int'(VEC[v].eWr), rq, "memory writes", 32'(wrCnt - wr0), 32'(VEC[v].eWr));
      if (VEC[v].eWr) begin
        chk(lastWrAddr == VEC[v].eWrAddr, 10, "write block address", 32'(lastWrAddr), 32'(VEC[v].eWrAddr));
        chk(lastWrData == VEC[v].eWrData, rq, "write data", lastWrData, VEC[v].eWrData);
        chk(lastWrSpace == VEC[v].sp, 4, "write space", 32'(lastWrSpace), 32'(VEC[v].sp));
      end

      @(posedge clk);
      #1 reqValid = 1'b0;
      @(negedge clk);
      chk(!respValid, 11, "single-cycle response", 32'(respValid), 32'h0);
    end

    // R10 every issued address was block aligned
    chk(alignBad == 0, 10, "unaligned memory address", 32'(alignBad), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule